// File: doc/BRIEF.md
# Scan-Coordinate Pattern Generator

This block drives a raster display from a single pixel clock. Two chained scan counters walk every position of the frame. The horizontal one moves on every clock and the vertical one moves when a line finishes. From their values the block produces active-low line and frame sync pulses and a flag that marks the visible area. The current column and row feed three independent image functions, each a purely combinational map from coordinates to a 1-bit-per-channel colour. A selector picks one of them.

The selector input is captured only once per frame, on the last pixel of the last visible line, so a change never splits a picture. The chosen colour is registered, and the sync pulses and the visible flag are delayed by the same one stage so that all outputs stay aligned. Outside the visible area the colour is forced to black. Each scan axis is a small phase machine with the states ACTIVE, FRONT, SYNC and BACK. Its transitions are ACTIVE to FRONT after the last visible position, FRONT to SYNC after the front porch, SYNC to BACK after the pulse, and BACK to ACTIVE on wrap. The axis leaves a state only when its step enable is high.

Defaults give 640x480 at a 25 MHz pixel clock. A line has 640 visible pixels, 16 front porch, 96 sync and 48 back porch. A frame has 480 visible lines, 10 front porch, 2 sync and 33 back porch. Every span and every image constant is a parameter.

Top module: `vga_pattern_top`

## Requirements
- R1: The column count advances on every clock and wraps after H_VIS+H_FP+H_SYNC+H_BP positions. The row count advances only on a column wrap, so a frame lasts exactly (H total)*(V total) clocks.
- R2: `hsync_n` is low exactly for columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1, on every line, and is high otherwise.
- R3: `vsync_n` is low exactly for rows V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1, for all columns of those rows, and is high otherwise.
- R4: `disp_en` is high exactly when column < H_VIS and row < V_VIS. All outputs show the scan position one clock after the counters hold it, so the first clock after reset release presents position (0,0).
- R5: While `disp_en` is low, `red`, `green` and `blue` are all 0.
- R6: Select code 0 (rectangle) gives black {r,g,b}=000 when RECT_X0 <= x <= RECT_X1 and RECT_Y0 <= y < RECT_Y1 (defaults 200, 400, 200, 400), and white 111 elsewhere.
- R7: Select code 1 (stripes) gives {r,g,b} = x[STRIPE_LOG2+2 : STRIPE_LOG2], which produces vertical bands 2^STRIPE_LOG2 pixels wide that cycle through all eight colours.
- R8: Select code 2 (squares) works with cell size 2^SQ_LOG2. If y[SQ_LOG2-1:0]==0 the pixel is pure red 100. Otherwise, if x[SQ_LOG2-1:0]==0, it is pure blue 001. Otherwise it is {x[SQ_LOG2], y[SQ_LOG2], x[SQ_LOG2]^y[SQ_LOG2]}.
- R9: Select code 3 gives black 000 over the whole visible area.
- R10: `mix_sel` is captured only on the clock where the column is at its last value and the row is V_VIS-1. The captured code governs every pixel from the next clock until the following capture, and changes at any other time have no effect.
- R11: During reset `hsync_n` and `vsync_n` are 1 and `disp_en`, `red`, `green` and `blue` are 0. The captured select resets to code 0, so the first frame after reset is the rectangle whatever `mix_sel` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mix_sel | input | 2 | Image function select, captured once per frame |
| hsync_n | output | 1 | Line sync, active low |
| vsync_n | output | 1 | Frame sync, active low |
| disp_en | output | 1 | High inside the visible area |
| red | output | 1 | Red channel |
| green | output | 1 | Green channel |
| blue | output | 1 | Blue channel |

## Verification
The bench runs the block with reduced timing and image parameters, so that each frame is short and every boundary is reached many times. It shows the rectangle first while `mix_sel` already asks for stripes, which separates the reset value of the captured select from the live input. It then moves to stripes, squares and black by changing `mix_sel` partway through a frame, including a burst of changes before one capture. Each frame's pixels are compared against the coordinate functions, which shows whether the capture point, the inclusive and exclusive rectangle edges, the gridline priority and the one-cycle alignment of colour, sync and enable are correct.

// File: rtl/vga_pat_pkg.sv
package vga_pat_pkg;

    typedef enum logic [1:0] {
        PH_ACTIVE = 2'd0,
        PH_FRONT  = 2'd1,
        PH_SYNC   = 2'd2,
        PH_BACK   = 2'd3
    } scan_phase_t;

    typedef enum logic [1:0] {
        MIX_RECT   = 2'd0,
        MIX_STRIPE = 2'd1,
        MIX_SQUARE = 2'd2,
        MIX_OFF    = 2'd3
    } mix_sel_t;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

endpackage

// File: rtl/scan_axis.sv
module scan_axis
    import vga_pat_pkg::*;
#(
    parameter int VIS  = 640,
    parameter int FP   = 16,
    parameter int SYNC = 96,
    parameter int BP   = 48,
    localparam int TOT = VIS + FP + SYNC + BP,
    localparam int W   = $clog2(TOT)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] pos,
    output logic         visible,
    output logic         sync_on
);

    localparam logic [W-1:0] LAST_ACT  = W'(VIS - 1);
    localparam logic [W-1:0] LAST_FP   = W'(VIS + FP - 1);
    localparam logic [W-1:0] LAST_SYNC = W'(VIS + FP + SYNC - 1);
    localparam logic [W-1:0] LAST_ALL  = W'(TOT - 1);

    scan_phase_t state_q, state_d;
    logic [W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (step) begin
            pos_q <= (pos_q == LAST_ALL) ? '0 : pos_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                PH_ACTIVE: if (pos_q == LAST_ACT)  state_d = PH_FRONT;
                PH_FRONT:  if (pos_q == LAST_FP)   state_d = PH_SYNC;
                PH_SYNC:   if (pos_q == LAST_SYNC) state_d = PH_BACK;
                PH_BACK:   if (pos_q == LAST_ALL)  state_d = PH_ACTIVE;
            endcase
        end
    end

    always_comb begin
        pos     = pos_q;
        visible = (state_q == PH_ACTIVE);
        sync_on = (state_q == PH_SYNC);
    end

endmodule

// File: rtl/pattern_mixers.sv
module pattern_mixers
    import vga_pat_pkg::*;
#(
    parameter int XW          = 10,
    parameter int YW          = 10,
    parameter int RECT_X0     = 200,
    parameter int RECT_X1     = 400,
    parameter int RECT_Y0     = 200,
    parameter int RECT_Y1     = 400,
    parameter int STRIPE_LOG2 = 5,
    parameter int SQ_LOG2     = 6
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  mix_sel_t      sel,
    output rgb_t          pix
);

    localparam logic [XW-1:0] RX0 = XW'(RECT_X0);
    localparam logic [XW-1:0] RX1 = XW'(RECT_X1);
    localparam logic [YW-1:0] RY0 = YW'(RECT_Y0);
    localparam logic [YW-1:0] RY1 = YW'(RECT_Y1);

    rgb_t rect_pix, stripe_pix, square_pix;

    // rectangle: right edge inclusive, bottom edge exclusive
    always_comb begin
        if (x >= RX0 && x <= RX1 && y >= RY0 && y < RY1) begin
            rect_pix = '{r: 1'b0, g: 1'b0, b: 1'b0};
        end else begin
            rect_pix = '{r: 1'b1, g: 1'b1, b: 1'b1};
        end
    end

    always_comb begin
        stripe_pix = rgb_t'(x[STRIPE_LOG2 +: 3]);
    end

    // gridlines first (horizontal wins), then mixed-colour cells
    always_comb begin
        if (y[SQ_LOG2-1:0] == '0) begin
            square_pix = '{r: 1'b1, g: 1'b0, b: 1'b0};
        end else if (x[SQ_LOG2-1:0] == '0) begin
            square_pix = '{r: 1'b0, g: 1'b0, b: 1'b1};
        end else begin
            square_pix = '{r: x[SQ_LOG2], g: y[SQ_LOG2],
                           b: x[SQ_LOG2] ^ y[SQ_LOG2]};
        end
    end

    always_comb begin
        unique case (sel)
            MIX_RECT:   pix = rect_pix;
            MIX_STRIPE: pix = stripe_pix;
            MIX_SQUARE: pix = square_pix;
            MIX_OFF:    pix = '0;
        endcase
    end

endmodule

// File: rtl/pixel_out_stage.sv
module pixel_out_stage
    import vga_pat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  rgb_t pix,
    input  logic visible,
    input  logic hsync_on,
    input  logic vsync_on,
    output logic hsync_n,
    output logic vsync_n,
    output logic disp_en,
    output rgb_t rgb
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n <= 1'b1;
            vsync_n <= 1'b1;
            disp_en <= 1'b0;
            rgb     <= '0;
        end else begin
            hsync_n <= !hsync_on;
            vsync_n <= !vsync_on;
            disp_en <= visible;
            rgb     <= visible ? pix : '0;
        end
    end

endmodule

// File: rtl/vga_pattern_top.sv
module vga_pattern_top
    import vga_pat_pkg::*;
#(
    parameter int H_VIS       = 640,
    parameter int H_FP        = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_VIS       = 480,
    parameter int V_FP        = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 33,
    parameter int RECT_X0     = 200,
    parameter int RECT_X1     = 400,
    parameter int RECT_Y0     = 200,
    parameter int RECT_Y1     = 400,
    parameter int STRIPE_LOG2 = 5,
    parameter int SQ_LOG2     = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mix_sel,
    output logic       hsync_n,
    output logic       vsync_n,
    output logic       disp_en,
    output logic       red,
    output logic       green,
    output logic       blue
);

    localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
    localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
    localparam int HW    = $clog2(H_TOT);
    localparam int VW    = $clog2(V_TOT);
    localparam logic [HW-1:0] H_LAST    = HW'(H_TOT - 1);
    localparam logic [VW-1:0] V_LAST_VS = VW'(V_VIS - 1);

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic h_vis, v_vis, h_sync_on, v_sync_on, h_last, grab_sel;
    mix_sel_t sel_q;
    rgb_t mix_pix, out_rgb;

    assign h_last   = (h_pos == H_LAST);
    assign grab_sel = h_last && (v_pos == V_LAST_VS);

    scan_axis #(.VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP)) u_hscan (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .pos(h_pos), .visible(h_vis), .sync_on(h_sync_on)
    );

    scan_axis #(.VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP)) u_vscan (
        .clk(clk), .rst_n(rst_n), .step(h_last),
        .pos(v_pos), .visible(v_vis), .sync_on(v_sync_on)
    );

    // select captured once per frame, at the edge into vertical blanking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= MIX_RECT;
        end else if (grab_sel) begin
            sel_q <= mix_sel_t'(mix_sel);
        end
    end

    pattern_mixers #(
        .XW(HW), .YW(VW),
        .RECT_X0(RECT_X0), .RECT_X1(RECT_X1),
        .RECT_Y0(RECT_Y0), .RECT_Y1(RECT_Y1),
        .STRIPE_LOG2(STRIPE_LOG2), .SQ_LOG2(SQ_LOG2)
    ) u_mix (
        .x(h_pos), .y(v_pos), .sel(sel_q), .pix(mix_pix)
    );

    pixel_out_stage u_out (
        .clk(clk), .rst_n(rst_n), .pix(mix_pix),
        .visible(h_vis && v_vis), .hsync_on(h_sync_on), .vsync_on(v_sync_on),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en), .rgb(out_rgb)
    );

    assign red   = out_rgb.r;
    assign green = out_rgb.g;
    assign blue  = out_rgb.b;

endmodule

// File: rtl/vga_pattern_checks.sv
module vga_pattern_checks #(
    parameter int H_SYNC = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hsync_n,
    input logic       vsync_n,
    input logic       disp_en,
    input logic       red,
    input logic       green,
    input logic       blue,
    input logic [1:0] sel_q
);

    logic [15:0] hs_low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_low <= '0;
        end else if (!hsync_n) begin
            hs_low <= hs_low + 1'b1;
        end else begin
            hs_low <= '0;
        end
    end

    AST_BLANK_IS_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (!red && !green && !blue)); // R5

    AST_HSYNC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync_n) |-> (hs_low == 16'(H_SYNC))); // R2

    AST_HSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !disp_en); // R2

    AST_VSYNC_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !disp_en); // R3

    AST_SEL_ONLY_IN_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sel_q) |-> !disp_en); // R10

endmodule

bind vga_pattern_top vga_pattern_checks #(.H_SYNC(H_SYNC)) u_checks (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_en(disp_en), .red(red), .green(green), .blue(blue),
    .sel_q(sel_q)
);

// File: tb/vga_pattern_top_test.sv
module vga_pattern_top_test;

    localparam int HV = 64, HF = 4, HS = 8, HB = 4;
    localparam int VV = 48, VF = 2, VS = 2, VB = 3;
    localparam int HT = HV + HF + HS + HB;
    localparam int VT = VV + VF + VS + VB;
    localparam int RX0 = 20, RX1 = 40, RY0 = 20, RY1 = 40;
    localparam int STL = 2, SQL = 3;

    typedef struct {
        bit       hs;
        bit       vs;
        bit       de;
        bit [2:0] rgb;
        int       mode;
        bit       first_frame;
        bit       switched;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mix_sel = 2'd1;
    logic hsync_n, vsync_n, disp_en, red, green, blue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    vga_pattern_top #(
        .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
        .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
        .RECT_X0(RX0), .RECT_X1(RX1), .RECT_Y0(RY0), .RECT_Y1(RY1),
        .STRIPE_LOG2(STL), .SQ_LOG2(SQL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .mix_sel(mix_sel),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
        .red(red), .green(green), .blue(blue)
    );

    function automatic bit [2:0] ref_pix(int x, int y, int mode);
        bit [2:0] c;
        case (mode)
            0: c = (x >= RX0 && x <= RX1 && y >= RY0 && y < RY1) ? 3'b000 : 3'b111;
            1: c = 3'((x >> STL) % 8);
            2: begin
                if ((y % (1 << SQL)) == 0)      c = 3'b100;
                else if ((x % (1 << SQL)) == 0) c = 3'b001;
                else begin
                    c[2] = 1'((x >> SQL) & 1);
                    c[1] = 1'((y >> SQL) & 1);
                    c[0] = c[2] ^ c[1];
                end
            end
            default: c = 3'b000;
        endcase
        return c;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // driver side of the scoreboard: reference scan model
    int mh = 0, mv = 0, msel = 0;
    bit m_first = 1'b1, m_switched = 1'b0;
    always @(posedge clk) begin
        if (rst_n) begin
            exp_t e;
            e.de  = (mh < HV) && (mv < VV);
            e.hs  = !((mh >= HV + HF) && (mh < HV + HF + HS));
            e.vs  = !((mv >= VV + VF) && (mv < VV + VF + VS));
            e.rgb = e.de ? ref_pix(mh, mv, msel) : 3'b000;
            e.mode = msel;
            e.first_frame = m_first;
            e.switched = m_switched;
            sb_q.push_back(e);
            if (mh == HT - 1 && mv == VV - 1) begin
                m_switched = (int'(mix_sel) != msel);
                msel = int'(mix_sel);
                m_first = 1'b0;
            end
            if (mh == HT - 1) begin
                mh = 0;
                mv = (mv == VT - 1) ? 0 : mv + 1;
            end else begin
                mh++;
            end
        end
    end

    // monitor side
    int fcnt = 0;
    bit seen_fall = 1'b0;
    logic prev_vs = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            fcnt++;
            if (prev_vs && !vsync_n) begin
                if (seen_fall) check(fcnt == HT * VT, "R1 frame length", fcnt, HT * VT);
                seen_fall = 1'b1;
                fcnt = 0;
            end
            prev_vs = vsync_n;
        end
        if (sb_q.size() > 0) begin
            exp_t e;
            bit [2:0] act;
            string tag;
            e = sb_q.pop_front();
            act = {red, green, blue};
            check(hsync_n == e.hs, "R2 hsync", int'(hsync_n), int'(e.hs));
            check(vsync_n == e.vs, "R3 vsync", int'(vsync_n), int'(e.vs));
            check(disp_en == e.de, "R4 enable", int'(disp_en), int'(e.de));
            if (!e.de)                tag = "R5 blank";
            else if (e.first_frame)   tag = "R11 first frame rectangle";
            else begin
                case (e.mode)
                    0:       tag = "R6 rectangle";
                    1:       tag = "R7 stripes";
                    2:       tag = "R8 squares";
                    default: tag = "R9 black";
                endcase
            end
            if (e.switched) tag = {tag, " after R10 capture"};
            check(act == e.rgb, tag, int'(act), int'(e.rgb));
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R11: outputs idle during reset
        check(hsync_n == 1'b1, "R11 reset hsync_n", int'(hsync_n), 1);
        check(vsync_n == 1'b1, "R11 reset vsync_n", int'(vsync_n), 1);
        check(disp_en == 1'b0, "R11 reset disp_en", int'(disp_en), 0);
        check({red, green, blue} == 3'b000, "R11 reset rgb", int'({red, green, blue}), 0);
        rst_n = 1'b1;
        repeat (HT * VT + 600) @(negedge clk);   // mid frame 1 (stripes)
        mix_sel = 2'd2;
        repeat (HT * VT) @(negedge clk);         // mid frame 2 (squares)
        mix_sel = 2'd3;
        repeat (HT * VT) @(negedge clk);         // mid frame 3 (black)
        mix_sel = 2'd1;
        repeat (300) @(negedge clk);
        mix_sel = 2'd2;
        repeat (300) @(negedge clk);
        mix_sel = 2'd0;                          // last value before capture wins
        repeat (HT * VT * 2) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule